// File: doc/BRIEF.md
# Multi-Page-Size Fully Associative Translation Buffer

This block holds a set of address translations and resolves a virtual address against all of them at once. Each stored translation has a tag word and an attribute word. The tag word carries a context number in its low bits and the virtual page above them. The attribute word carries a valid flag, a page-size code, protection flags and the physical frame. Software loads an entry by index through a write port. A lookup presents a 64-bit virtual address, the current context, a user flag, a write flag and a flag that says whether the lookup is data-side.

One cycle after a lookup, the block reports exactly one of three outcomes: a hit, with the physical address and write permission; a miss; or a protection fault. A fault updates a 4-bit fault status register and a fault address register, and the status register records when an earlier fault was never cleared. When translation is disabled, every lookup hits with the identity mapping. Entries stay empty after reset and the status register is cleared only by reset, so the surrounding logic owns refill and the handling of faults.

Top module: `vpage_tlb`

## Requirements
- R1: After reset, all result outputs, the fault status register and the fault address register are zero, and every entry's tag and attribute words are zero.
- R2: An entry written with `wr_en` high is used by lookups from the next cycle on. A lookup in the same cycle as the write sees the previous contents.
- R3: Attribute bits [62:61] give the page size: 0 = 8 KB, 1 = 64 KB, 2 = 512 KB, 3 = 4 MB. The size excludes the low 13, 16, 19 or 22 virtual address bits from the compare, and the tag bits above that point are compared with the full 64-bit virtual address.
- R4: Tag bits [12:0] must equal `lk_ctx` exactly for the entry to match.
- R5: When several entries match, the entry with the lowest index decides the outcome.
- R6: On a hit, `res_pa` bits [40:0] take attribute bits at and above the page boundary and virtual address bits below it. `res_pa` bits [63:41] are zero.
- R7: A lookup that matches no entry reports `res_miss`.
- R8: A matching valid entry with attribute bit 2 (privileged) set reports a fault for a user lookup.
- R9: A write lookup that is data-side faults on a matching entry whose attribute bit 1 (writable) is clear. An instruction-side lookup never makes this check. On a hit, `res_wperm` equals bit 1 for data-side lookups and is 0 for instruction-side lookups.
- R10: A matching entry whose attribute bit 63 (valid) is clear takes part in the match and reports a fault.
- R11: On a fault, the status register becomes (2 if it was nonzero, else 0) OR {user, write AND data-side, 0, 1} in bits [3:0], and the fault address register takes the virtual address. Without a fault, both registers hold their values.
- R12: With `xlat_en` low, a lookup reports a hit with `res_pa` equal to the virtual address and `res_wperm` set, whatever the entries hold.
- R13: The results appear in the cycle after `lk_valid`, and at most one of hit, miss and fault is set. In a cycle after no lookup, all three are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_en | input | 1 | Translation enable; low gives identity mapping |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_tag | input | 64 | Tag word: virtual page and context in [12:0] |
| wr_attr | input | 64 | Attribute word: valid, size, frame, flags |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 64 | Virtual address |
| lk_ctx | input | 13 | Current context |
| lk_user | input | 1 | Lookup is from user mode |
| lk_write | input | 1 | Lookup is a store |
| lk_data | input | 1 | Lookup is data-side (enables write check) |
| res_hit | output | 1 | Translation found |
| res_miss | output | 1 | No entry matched |
| res_fault | output | 1 | Protection fault |
| res_wperm | output | 1 | Write permitted on the hit page |
| res_pa | output | 64 | Physical address |
| fault_status | output | 4 | Fault status register |
| fault_addr | output | 64 | Fault address register |

## Verification
The hardest case to reach is a status overflow, which needs two faults with no reset between them. It comes with a second case: the entries left zero by reset match context 0 at low addresses and fault as invalid. The bench uses this. Right after reset, before anything is loaded, it sends three context-0 lookups with different user, write and side flags. This gives a first fault and then two overflows, and it shows that the write bit is gated by the data-side flag. The priority case places a 4 MB entry at a higher index over the same region as an 8 KB entry. One address inside the 8 KB page and one outside it then show which entry decides.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W       = 64;
    localparam int ATTR_W     = 64;
    localparam int FSR_W      = 4;

    // attribute word field positions (decoded by the lookup logic)
    localparam int A_VALID    = 63;
    localparam int A_SIZE_HI  = 62;
    localparam int A_SIZE_LO  = 61;
    localparam int A_PRIV     = 2;
    localparam int A_WRITE    = 1;

    // page geometry: smallest page excludes 13 bits, each size step adds 3
    localparam int BASE_SHIFT = 13;
    localparam int SHIFT_STEP = 3;

    typedef enum logic [1:0] {
        PG_8K   = 2'd0,
        PG_64K  = 2'd1,
        PG_512K = 2'd2,
        PG_4M   = 2'd3
    } pg_size_e;

    // ones on the bits that take part in the compare
    function automatic logic [VA_W-1:0] page_mask(input logic [1:0] sz);
        logic [VA_W-1:0] m;
        int              sh;
        sh = BASE_SHIFT + SHIFT_STEP * int'(sz);
        m  = '1;
        m  = m << sh;
        return m;
    endfunction

    typedef struct packed {
        logic            hit;
        logic            miss;
        logic            fault;
        logic            wperm;
        logic [VA_W-1:0] pa;
    } lk_result_t;

    typedef struct packed {
        lk_result_t       res;
        logic [FSR_W-1:0] fsr;
        logic [VA_W-1:0]  far;
    } tlb_state_t;

endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [VA_W-1:0]                wr_tag,
    input  logic [ATTR_W-1:0]              wr_attr,
    output logic [ENTRIES-1:0][VA_W-1:0]   tag_arr,
    output logic [ENTRIES-1:0][ATTR_W-1:0] attr_arr
);

    logic [ENTRIES-1:0][VA_W-1:0]   tag_d, tag_q;
    logic [ENTRIES-1:0][ATTR_W-1:0] attr_d, attr_q;

    always_comb begin
        tag_d  = tag_q;
        attr_d = attr_q;
        if (wr_en) begin
            tag_d[wr_idx]  = wr_tag;
            attr_d[wr_idx] = wr_attr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            attr_q <= '0;
        end else begin
            tag_q  <= tag_d;
            attr_q <= attr_d;
        end
    end

    assign tag_arr  = tag_q;
    assign attr_arr = attr_q;

endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int CTX_W   = 13
) (
    input  logic [VA_W-1:0]                lk_va,
    input  logic [CTX_W-1:0]               lk_ctx,
    input  logic [ENTRIES-1:0][VA_W-1:0]   tag_arr,
    input  logic [ENTRIES-1:0][ATTR_W-1:0] attr_arr,
    output logic [ENTRIES-1:0]             match_vec
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic [VA_W-1:0] cmp_mask;
        logic            ctx_eq;
        logic            page_eq;

        always_comb begin
            cmp_mask = page_mask(attr_arr[i][A_SIZE_HI:A_SIZE_LO]);
            ctx_eq   = (tag_arr[i][CTX_W-1:0] == lk_ctx);
            page_eq  = (((lk_va ^ tag_arr[i]) & cmp_mask) == '0);
        end

        assign match_vec[i] = ctx_eq && page_eq;
    end

endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] req_vec,
    output logic               any_set,
    output logic [IDX_W-1:0]   first_idx
);

    always_comb begin
        any_set   = 1'b0;
        first_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req_vec[i]) begin
                any_set   = 1'b1;
                first_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/vpage_tlb.sv
module vpage_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int CTX_W   = 13,
    parameter int PA_MSB  = 40,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlat_en,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VA_W-1:0]   wr_tag,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [CTX_W-1:0]  lk_ctx,
    input  logic              lk_user,
    input  logic              lk_write,
    input  logic              lk_data,
    output logic              res_hit,
    output logic              res_miss,
    output logic              res_fault,
    output logic              res_wperm,
    output logic [VA_W-1:0]   res_pa,
    output logic [FSR_W-1:0]  fault_status,
    output logic [VA_W-1:0]   fault_addr
);

    logic [ENTRIES-1:0][VA_W-1:0]   tag_arr;
    logic [ENTRIES-1:0][ATTR_W-1:0] attr_arr;
    logic [ENTRIES-1:0]             match_vec;
    logic                           any_match;
    logic [IDX_W-1:0]               sel_idx;

    tlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_tag   (wr_tag),
        .wr_attr  (wr_attr),
        .tag_arr  (tag_arr),
        .attr_arr (attr_arr)
    );

    tlb_cam #(.ENTRIES(ENTRIES), .CTX_W(CTX_W)) u_cam (
        .lk_va     (lk_va),
        .lk_ctx    (lk_ctx),
        .tag_arr   (tag_arr),
        .attr_arr  (attr_arr),
        .match_vec (match_vec)
    );

    tlb_pick #(.ENTRIES(ENTRIES)) u_pick (
        .req_vec   (match_vec),
        .any_set   (any_match),
        .first_idx (sel_idx)
    );

    tlb_state_t      st_d, st_q;
    logic [ATTR_W-1:0] sel_attr;
    logic [VA_W-1:0]   sel_mask;
    logic [PA_MSB:0]   frame;
    logic              bad_valid, bad_priv, bad_write, any_bad;
    logic [FSR_W-1:0]  fsr_base;
    logic              unused_ok;

    assign sel_attr  = attr_arr[sel_idx];
    assign sel_mask  = page_mask(sel_attr[A_SIZE_HI:A_SIZE_LO]);
    assign frame     = (sel_attr[PA_MSB:0] & sel_mask[PA_MSB:0])
                     | (lk_va[PA_MSB:0] & ~sel_mask[PA_MSB:0]);
    assign bad_valid = !sel_attr[A_VALID];
    assign bad_priv  = sel_attr[A_PRIV] && lk_user;
    assign bad_write = lk_data && lk_write && !sel_attr[A_WRITE];
    assign any_bad   = bad_valid || bad_priv || bad_write;
    assign fsr_base  = (st_q.fsr != '0) ? FSR_W'(2) : '0;
    assign unused_ok = ^{sel_attr[A_SIZE_LO-1:PA_MSB+1], sel_mask[VA_W-1:PA_MSB+1]};

    always_comb begin
        st_d     = st_q;
        st_d.res = '0;
        if (lk_valid) begin
            if (!xlat_en) begin
                st_d.res.hit   = 1'b1;
                st_d.res.wperm = 1'b1;
                st_d.res.pa    = lk_va;
            end else if (!any_match) begin
                st_d.res.miss  = 1'b1;
            end else if (any_bad) begin
                st_d.res.fault = 1'b1;
                st_d.fsr       = fsr_base | {lk_user, lk_write & lk_data, 1'b0, 1'b1};
                st_d.far       = lk_va;
            end else begin
                st_d.res.hit   = 1'b1;
                st_d.res.wperm = sel_attr[A_WRITE] & lk_data;
                st_d.res.pa    = VA_W'(frame);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_hit      = st_q.res.hit;
    assign res_miss     = st_q.res.miss;
    assign res_fault    = st_q.res.fault;
    assign res_wperm    = st_q.res.wperm;
    assign res_pa       = st_q.res.pa;
    assign fault_status = st_q.fsr;
    assign fault_addr   = st_q.far;

endmodule

// File: rtl/tlb_checker.sv
module tlb_checker
    import tlb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             xlat_en,
    input logic             lk_valid,
    input logic [VA_W-1:0]  lk_va,
    input logic             res_hit,
    input logic             res_miss,
    input logic             res_fault,
    input logic [VA_W-1:0]  res_pa,
    input logic [FSR_W-1:0] fault_status,
    input logic [VA_W-1:0]  fault_addr
);

    p_one_outcome_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_hit, res_miss, res_fault}));

    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !(res_hit || res_miss || res_fault));

    p_identity_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !xlat_en) |=> (res_hit && res_pa == $past(lk_va)));

    p_far_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && xlat_en) |=> (res_fault -> fault_addr == $past(lk_va)));

    p_fsr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !res_fault |-> ($stable(fault_status) && $stable(fault_addr)));

    p_fsr_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (res_fault && $past(fault_status) != '0) |-> (fault_status[1] && fault_status[0]));

    p_fsr_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (res_fault && $past(fault_status) == '0) |-> (!fault_status[1] && fault_status[0]));

endmodule

bind vpage_tlb tlb_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .xlat_en      (xlat_en),
    .lk_valid     (lk_valid),
    .lk_va        (lk_va),
    .res_hit      (res_hit),
    .res_miss     (res_miss),
    .res_fault    (res_fault),
    .res_pa       (res_pa),
    .fault_status (fault_status),
    .fault_addr   (fault_addr)
);

// File: tb/vpage_tlb_tb.sv
`timescale 1ns/1ps
module vpage_tlb_tb;

    localparam logic [1:0] K_HIT = 2'd1, K_MISS = 2'd2, K_FAULT = 2'd3;

    typedef struct packed {
        logic [63:0] va;
        logic [12:0] ctx;
        logic        user;
        logic        wr;
        logic        dside;
        logic [1:0]  kind;
        logic [5:0]  idx;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{64'h0000_0000_1000_0ABC, 13'd5, 1'b0, 1'b1, 1'b1, K_HIT,   6'd0, 4'd6},  // R6 8K
        '{64'h0000_0000_2000_F123, 13'd5, 1'b0, 1'b0, 1'b1, K_HIT,   6'd1, 4'd3},  // R3 64K
        '{64'h0000_0000_2001_0000, 13'd5, 1'b0, 1'b0, 1'b1, K_MISS,  6'd0, 4'd3},  // R3 64K edge
        '{64'h0000_0000_2000_0010, 13'd5, 1'b1, 1'b0, 1'b1, K_FAULT, 6'd0, 4'd8},  // R8 user on priv
        '{64'h0000_7000_0007_FFF0, 13'd7, 1'b0, 1'b0, 1'b1, K_HIT,   6'd2, 4'd3},  // R3 512K
        '{64'h0000_7000_0008_0000, 13'd7, 1'b0, 1'b0, 1'b1, K_MISS,  6'd0, 4'd3},  // R3 512K edge
        '{64'h0000_7000_0000_0100, 13'd7, 1'b0, 1'b1, 1'b1, K_FAULT, 6'd0, 4'd9},  // R9 data write ro
        '{64'h0000_7000_0000_0100, 13'd7, 1'b0, 1'b1, 1'b0, K_HIT,   6'd2, 4'd9},  // R9 instr side
        '{64'h0000_0000_403F_FFFF, 13'd7, 1'b0, 1'b1, 1'b1, K_HIT,   6'd3, 4'd6},  // R6 4M
        '{64'h0000_0000_4040_0000, 13'd7, 1'b0, 1'b0, 1'b1, K_MISS,  6'd0, 4'd3},  // R3 4M edge
        '{64'h0000_0000_1000_0ABC, 13'd6, 1'b0, 1'b0, 1'b1, K_MISS,  6'd0, 4'd4},  // R4 ctx
        '{64'h0000_0000_6000_0010, 13'd9, 1'b0, 1'b0, 1'b1, K_FAULT, 6'd0, 4'd10}, // R10 invalid
        '{64'h0000_0000_1020_0000, 13'd5, 1'b0, 1'b0, 1'b1, K_HIT,   6'd4, 4'd5},  // R5 only e4
        '{64'h0000_0000_1000_0004, 13'd5, 1'b1, 1'b0, 1'b1, K_HIT,   6'd0, 4'd5},  // R5 e0 over e4
        '{64'h0000_0000_3000_1FFF, 13'd5, 1'b0, 1'b0, 1'b1, K_HIT,   6'd6, 4'd3},  // R3 8K top
        '{64'h0000_0000_3000_2000, 13'd5, 1'b0, 1'b0, 1'b1, K_MISS,  6'd0, 4'd3},  // R3 8K edge
        '{64'h0000_6000_0000_0100, 13'd7, 1'b0, 1'b0, 1'b1, K_MISS,  6'd0, 4'd7},  // R7 high bits
        '{64'h0000_0000_5555_0000, 13'd5, 1'b0, 1'b0, 1'b1, K_MISS,  6'd0, 4'd7}   // R7 empty area
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlat_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [63:0] wr_tag = '0;
    logic [63:0] wr_attr = '0;
    logic        lk_valid = 1'b0;
    logic [63:0] lk_va = '0;
    logic [12:0] lk_ctx = '0;
    logic        lk_user = 1'b0;
    logic        lk_write = 1'b0;
    logic        lk_data = 1'b0;
    logic        res_hit, res_miss, res_fault, res_wperm;
    logic [63:0] res_pa;
    logic [3:0]  fault_status;
    logic [63:0] fault_addr;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;
    logic [63:0] m_attr [64];

    always #5 clk = ~clk;

    vpage_tlb u_dut (
        .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_attr(wr_attr),
        .lk_valid(lk_valid), .lk_va(lk_va), .lk_ctx(lk_ctx), .lk_user(lk_user),
        .lk_write(lk_write), .lk_data(lk_data),
        .res_hit(res_hit), .res_miss(res_miss), .res_fault(res_fault),
        .res_wperm(res_wperm), .res_pa(res_pa),
        .fault_status(fault_status), .fault_addr(fault_addr)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_pa(input logic [63:0] attr, input logic [63:0] va);
        logic [63:0] m;
        m = '1;
        m = m << (13 + 3 * int'(attr[62:61]));
        return ((attr & m) | (va & ~m)) & 64'h0000_01FF_FFFF_FFFF;
    endfunction

    task automatic load(input int idx, input logic [63:0] va, input logic [12:0] ctx,
                        input logic [1:0] sz, input logic [63:0] pa, input logic vld,
                        input logic [7:0] flags);
        wr_en   = 1'b1;
        wr_idx  = 6'(idx);
        wr_tag  = (va & ~64'h1FFF) | 64'(ctx);
        wr_attr = {vld, sz, 61'd0} | pa | 64'(flags);
        m_attr[idx] = wr_attr;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input logic [63:0] va, input logic [12:0] ctx,
                          input logic u, input logic w, input logic d);
        lk_valid = 1'b1; lk_va = va; lk_ctx = ctx;
        lk_user = u; lk_write = w; lk_data = d;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) m_attr[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!res_hit && !res_miss && !res_fault, "R1", "outcomes", {61'd0, res_hit, res_miss, res_fault}, 0);
        check(fault_status == 4'd0, "R1", "fsr", 64'(fault_status), 0);
        check(fault_addr == 64'd0, "R1", "far", fault_addr, 0);
        rst_n = 1'b1;
        xlat_en = 1'b1;
        @(negedge clk);

        // R10 R11: zeroed entries match ctx 0 at low addresses and fault as invalid
        lookup(64'h1000, 13'd0, 1'b0, 1'b0, 1'b1);
        check(res_fault, "R10", "reset entry fault", 64'(res_fault), 1);
        check(fault_status == 4'h1, "R11", "first fsr", 64'(fault_status), 64'h1);
        check(fault_addr == 64'h1000, "R11", "far", fault_addr, 64'h1000);
        lookup(64'h0, 13'd0, 1'b1, 1'b1, 1'b1);
        check(fault_status == 4'hF, "R11", "overflow user write", 64'(fault_status), 64'hF);
        lookup(64'h1F00, 13'd0, 1'b0, 1'b1, 1'b0);
        check(fault_status == 4'h3, "R11", "overflow instr write", 64'(fault_status), 64'h3);
        check(fault_addr == 64'h1F00, "R11", "far second", fault_addr, 64'h1F00);

        // entries for the table
        load(0, 64'h1000_0000,         13'd5, 2'd0, 64'h0AB0_0000,   1'b1, 8'h02);
        load(1, 64'h2000_0000,         13'd5, 2'd1, 64'h4000_0000,   1'b1, 8'h06);
        load(2, 64'h7000_0000_0000,    13'd7, 2'd2, 64'h8008_0000,   1'b1, 8'h00);
        load(3, 64'h4000_0000,         13'd7, 2'd3, 64'h1_2340_0000, 1'b1, 8'h02);
        load(4, 64'h1000_0000,         13'd5, 2'd3, 64'hC000_0000,   1'b1, 8'h42);
        load(5, 64'h6000_0000,         13'd9, 2'd0, 64'h0,           1'b0, 8'h02);
        load(6, 64'h3000_0000,         13'd5, 2'd0, 64'h0777_E000,   1'b1, 8'h02);

        for (int v = 0; v < NV; v++) begin
            string rq;
            logic [1:0] got;
            rq = $sformatf("R%0d", VECS[v].req);
            lookup(VECS[v].va, VECS[v].ctx, VECS[v].user, VECS[v].wr, VECS[v].dside);
            got = res_hit ? K_HIT : res_miss ? K_MISS : res_fault ? K_FAULT : 2'd0;
            check(got == VECS[v].kind && $countones({res_hit, res_miss, res_fault}) == 1,
                  rq, $sformatf("vector %0d outcome", v), 64'(got), 64'(VECS[v].kind));
            if (VECS[v].kind == K_HIT) begin
                check(res_pa == exp_pa(m_attr[VECS[v].idx], VECS[v].va), rq,
                      $sformatf("vector %0d pa", v), res_pa, exp_pa(m_attr[VECS[v].idx], VECS[v].va));
                check(res_wperm == (m_attr[VECS[v].idx][1] & VECS[v].dside), rq,
                      $sformatf("vector %0d wperm", v), 64'(res_wperm),
                      64'(m_attr[VECS[v].idx][1] & VECS[v].dside));
            end
        end

        // R12 identity when disabled, even on a privileged user write
        xlat_en = 1'b0;
        lookup(64'hDEAD_BEEF_2000_0010, 13'd5, 1'b1, 1'b1, 1'b1);
        check(res_hit && res_wperm, "R12", "identity hit", {62'd0, res_hit, res_wperm}, 64'h3);
        check(res_pa == 64'hDEAD_BEEF_2000_0010, "R12", "identity pa", res_pa, 64'hDEAD_BEEF_2000_0010);
        xlat_en = 1'b1;

        // R2 write and lookup in the same cycle: old contents, then new
        wr_en = 1'b1; wr_idx = 6'd10;
        wr_tag = 64'h7000_0000 | 64'd11;
        wr_attr = {1'b1, 2'd0, 61'd0} | 64'h0123_4000 | 64'h2;
        m_attr[10] = wr_attr;
        lk_valid = 1'b1; lk_va = 64'h7000_0040; lk_ctx = 13'd11;
        lk_user = 1'b0; lk_write = 1'b0; lk_data = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0;
        check(res_miss, "R2", "same cycle sees old", 64'(res_miss), 1);
        lookup(64'h7000_0040, 13'd11, 1'b0, 1'b0, 1'b1);
        check(res_hit, "R2", "next cycle hit", 64'(res_hit), 1);
        check(res_pa == 64'h0123_4040, "R2", "new pa", res_pa, 64'h0123_4040);

        // R13 idle cycle clears outcome
        @(negedge clk);
        check(!res_hit && !res_miss && !res_fault, "R13", "idle quiet",
              {61'd0, res_hit, res_miss, res_fault}, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule